// File: doc/BRIEF.md
# Serial BCD Digit Adder

This block adds two decimal numbers of any length, one BCD digit of each operand per clock cycle, least significant digit first. On every cycle where the caller raises the digit strobe, the block forms the sum of the two input digits and the stored carry. It registers one BCD sum digit and keeps the decimal carry as its only piece of arithmetic state. An addition of N digits therefore occupies N consecutive strobed cycles, and the result digits come out in the same order one cycle later.

A new addition begins with a start pulse, which clears the carry. If the pulse coincides with a strobed digit, that digit is treated as the first digit of the new number, with a carry-in of zero. The current carry is always visible on a port. After the last digit of an addition, the caller can read it as the extra leading digit of the result. An input digit above 9 is not rejected. It is flagged on an error output that travels alongside the corresponding sum digit, and the arithmetic is still carried out on the raw 4-bit values.

Top module: `bcd_serial_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `sum_vld`, `carry_out`, `dig_err` and `sum_dig` are all 0.
- R2: For a strobed cycle, `sum_dig` after the next clock edge equals (a + b + cin) mod 10, where a and b are the unsigned 4-bit input digits and cin is the carry-in.
- R3: After a strobed cycle's clock edge, `carry_out` is 1 when a + b + cin is 10 or more, and 0 otherwise.
- R4: The carry-in of a strobed cycle is the current `carry_out`, except when `start` is high in that same cycle; then the carry-in is 0.
- R5: A `start` pulse without a strobe sets `carry_out` to 0 after the clock edge and produces no result.
- R6: `sum_vld` is high for exactly one cycle after each strobed cycle, one clock edge later, and is low after any cycle without a strobe.
- R7: On a cycle with neither strobe nor start, `carry_out` and `sum_dig` keep their values. Idle gaps between digits therefore do not disturb an addition.
- R8: `dig_err` is high, together with `sum_vld`, exactly for results whose input digit a or b was above 9. R2 and R3 still apply to those raw values; for example, 15 + 15 + 1 gives digit 1 and carry 1.
- R9: An N-digit addition fed on N consecutive strobed cycles yields N sum digits on N consecutive cycles. On the last of those cycles, `carry_out` holds the final leading carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new addition: clears the carry |
| dig_vld | input | 1 | Input digits valid this cycle |
| dig_a | input | 4 | Digit of operand A (BCD) |
| dig_b | input | 4 | Digit of operand B (BCD) |
| sum_dig | output | 4 | Registered sum digit |
| sum_vld | output | 1 | `sum_dig` holds a fresh result |
| carry_out | output | 1 | Current decimal carry |
| dig_err | output | 1 | Result came from an out-of-range digit |

## Verification
The carry bit is the only hidden state. A wrong carry never shows in the digit where it goes wrong: it appears in `carry_out` right after that edge, and in the next strobed digit as an off-by-one sum, which can be any number of idle cycles later. The scoreboard therefore compares `carry_out` on every cycle, including idle cycles and start-only cycles, rather than only when `sum_vld` is high. Long ripple chains such as 99999999 + 1 expose a carry that is dropped or held for one digit too long.

// File: rtl/bcd_ser_pkg.sv
package bcd_ser_pkg;

  localparam int DIG_W   = 4;
  localparam int TOT_W   = DIG_W + 1;
  localparam int DEC_MAX = 9;

  typedef logic [DIG_W-1:0] digit_t;
  typedef logic [TOT_W-1:0] total_t;

  // raw sum of two digits plus carry, wide enough for 15+15+1
  function automatic total_t dig_total(input digit_t a, input digit_t b, input logic c);
    return total_t'(a) + total_t'(b) + total_t'(c);
  endfunction

  // remainder modulo ten of a total up to 31
  function automatic digit_t dig_mod10(input total_t t);
    total_t r;
    if (t >= total_t'(30))      r = t - total_t'(30);
    else if (t >= total_t'(20)) r = t - total_t'(20);
    else if (t >= total_t'(10)) r = t - total_t'(10);
    else                        r = t;
    return digit_t'(r);
  endfunction

  function automatic logic dig_carry(input total_t t);
    return t >= total_t'(10);
  endfunction

  function automatic logic dig_in_range(input digit_t d);
    return d <= digit_t'(DEC_MAX);
  endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_ser_pkg::*;
(
  input  digit_t in_a,
  input  digit_t in_b,
  input  logic   cin,
  output digit_t sum,
  output logic   cout,
  output logic   bad
);
  total_t tot;

  always_comb begin
    tot  = dig_total(in_a, in_b, cin);
    sum  = dig_mod10(tot);
    cout = dig_carry(tot);
    bad  = !dig_in_range(in_a) || !dig_in_range(in_b);
  end

  always_comb begin
    AST_CELL_DIGIT_RANGE: assert (sum <= digit_t'(DEC_MAX)); // R2
  end
endmodule

// File: rtl/bcd_carry_state.sv
module bcd_carry_state (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  input  logic cnext,
  output logic cin_eff,
  output logic carry_q
);
  // a clear in the same cycle as a digit makes that digit the first one
  assign cin_eff = clear ? 1'b0 : carry_q;

  always_ff @(posedge clk) begin
    if (rst)        carry_q <= 1'b0;
    else if (step)  carry_q <= cnext;
    else if (clear) carry_q <= 1'b0;
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (clear && !step) |=> !carry_q); // R5

  AST_CARRY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(carry_q)); // R7
endmodule

// File: rtl/bcd_result_stage.sv
module bcd_result_stage
  import bcd_ser_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step,
  input  digit_t sum_in,
  input  logic   bad_in,
  output digit_t sum_q,
  output logic   vld_q,
  output logic   err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= step;
      err_q <= step && bad_in;
      if (step) sum_q <= sum_in;
    end
  end

  AST_VLD_ONE_LATER: assert property (@(posedge clk) disable iff (rst)
    step |=> vld_q); // R6

  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (rst)
    !step |=> !vld_q); // R6

  AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sum_q)); // R7

  AST_ERR_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
    err_q |-> vld_q); // R8
endmodule

// File: rtl/bcd_serial_adder.sv
module bcd_serial_adder
  import bcd_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dig_vld,
  input  logic [DIG_W-1:0] dig_a,
  input  logic [DIG_W-1:0] dig_b,
  output logic [DIG_W-1:0] sum_dig,
  output logic             sum_vld,
  output logic             carry_out,
  output logic             dig_err
);
  // named internal events for checking
  logic   ev_step;
  logic   ev_clear;
  logic   ev_bad;
  logic   ev_cnext;
  logic   cin_eff;
  digit_t cell_sum;

  assign ev_step  = dig_vld;
  assign ev_clear = start;

  bcd_carry_state u_carry (
    .clk     (clk),
    .rst     (rst),
    .clear   (ev_clear),
    .step    (ev_step),
    .cnext   (ev_cnext),
    .cin_eff (cin_eff),
    .carry_q (carry_out)
  );

  bcd_digit_cell u_cell (
    .in_a (dig_a),
    .in_b (dig_b),
    .cin  (cin_eff),
    .sum  (cell_sum),
    .cout (ev_cnext),
    .bad  (ev_bad)
  );

  bcd_result_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .step   (ev_step),
    .sum_in (cell_sum),
    .bad_in (ev_bad),
    .sum_q  (sum_dig),
    .vld_q  (sum_vld),
    .err_q  (dig_err)
  );

  AST_START_FIRST_DIGIT: assert property (@(posedge clk) disable iff (rst)
    (start && dig_vld && dig_a == '0 && dig_b == '0) |=> !carry_out); // R4

  AST_SUM_IS_DECIMAL: assert property (@(posedge clk) disable iff (rst)
    sum_vld |-> (sum_dig <= digit_t'(DEC_MAX))); // R2

  AST_BIG_TOTAL_CARRIES: assert property (@(posedge clk) disable iff (rst)
    (dig_vld && (dig_a + dig_b) >= 10) |=> carry_out); // R3
endmodule

// File: tb/bcd_serial_adder_tb_top.sv
module bcd_serial_adder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       dig_vld = 1'b0;
  logic [3:0] dig_a = '0;
  logic [3:0] dig_b = '0;
  logic [3:0] sum_dig;
  logic       sum_vld;
  logic       carry_out;
  logic       dig_err;

  always #5 clk = ~clk;

  bcd_serial_adder dut_i (
    .clk(clk), .rst(rst), .start(start), .dig_vld(dig_vld),
    .dig_a(dig_a), .dig_b(dig_b), .sum_dig(sum_dig), .sum_vld(sum_vld),
    .carry_out(carry_out), .dig_err(dig_err)
  );

  typedef struct {
    logic       vld;
    logic [3:0] sum;
    logic       err;
    logic       cy;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic m_carry = 1'b0;
  logic [3:0] m_sum = '0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one call per clock cycle, expectation for the outputs after the next edge
  task automatic step(input logic v, input logic st, input int a, input int b, input string tag);
    exp_t e;
    int tot;
    @(negedge clk);
    dig_vld = v; start = st; dig_a = 4'(a); dig_b = 4'(b);
    if (v) begin
      tot = a + b + (st ? 0 : int'(m_carry));
      m_sum = 4'(tot % 10);
      m_carry = (tot >= 10);
      e.err = (a > 9) || (b > 9);
    end else begin
      if (st) m_carry = 1'b0;
      e.err = 1'b0;
    end
    e.vld = v; e.sum = m_sum; e.cy = m_carry; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic add_num(input longint unsigned a, input longint unsigned b, input int nd, input string tag);
    longint unsigned ra = a;
    longint unsigned rb = b;
    for (int i = 0; i < nd; i++) begin
      step(1'b1, i == 0, int'(ra % 10), int'(rb % 10), tag);
      ra = ra / 10; rb = rb / 10;
    end
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({"R6 vld ", e.tag}, int'(sum_vld), int'(e.vld));
        check({"R3 carry ", e.tag}, int'(carry_out), int'(e.cy));
        check({"R8 err ", e.tag}, int'(dig_err), int'(e.err));
        if (e.vld) check({"R2 sum ", e.tag}, int'(sum_dig), int'(e.sum));
        else       check({"R7 held sum ", e.tag}, int'(sum_dig), int'(e.sum));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 sum_vld", int'(sum_vld), 0);
    check("R1 carry_out", int'(carry_out), 0);
    check("R1 dig_err", int'(dig_err), 0);
    check("R1 sum_dig", int'(sum_dig), 0);
    @(negedge clk); rst = 1'b0;

    add_num(64'd99999999, 64'd1, 8, "R9 ripple");
    step(1'b0, 1'b0, 0, 0, "R9 after");
    add_num(64'd12345678, 64'd87654321, 8, "R9 no carry");
    add_num(64'd5, 64'd5, 1, "R3 ten");
    step(1'b0, 1'b0, 0, 0, "R7 idle");
    step(1'b0, 1'b0, 0, 0, "R7 idle");
    step(1'b1, 1'b0, 4, 4, "R4 carry in");
    add_num(64'd9, 64'd9, 1, "R3 eighteen");
    step(1'b1, 1'b1, 0, 0, "R4 start with digit");
    add_num(64'd7, 64'd8, 1, "R3 fifteen");
    step(1'b0, 1'b1, 0, 0, "R5 start alone");
    step(1'b1, 1'b0, 2, 3, "R5 after clear");
    step(1'b1, 1'b1, 12, 5, "R8 a over");
    step(1'b1, 1'b0, 15, 15, "R8 both over");
    step(1'b1, 1'b0, 3, 10, "R8 b over");
    step(1'b1, 1'b0, 9, 0, "R8 back in range");
    add_num(64'd4567, 64'd5433, 4, "R9 four digits");
    step(1'b0, 1'b0, 0, 0, "R9 final carry held");
    step(1'b0, 1'b0, 0, 0, "R7 idle end");
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule